// File: doc/BRIEF.md
# Calibrating Serial Bit-Rate Detector and Tick Generator

This block learns the bit rate of an asynchronous serial link from the link itself. After reset it waits and does not lock. The host must open with the calibration character 80H. With a low start bit, least-significant-bit-first data and a high stop bit, that character appears on the line as one unbroken low stretch of exactly eight bit times, with high levels before and after it. The block counts system clocks across that low stretch and divides the count by eight, rounding to nearest, to get the bit period. It stores that period and raises its lock flag. A stretch that is too short or too long for the supported rate range raises a sticky error flag instead.

Once locked, the block acts as a baud-rate generator for a companion character framer. Each start-bit falling edge seen while no frame is in progress sets the generator's phase. The generator first issues a half-period tick that the framer uses to check the start bit. It then issues eight full-period ticks for mid-bit sampling of the data bits, and finally a stop tick one and a half periods after the last data tick, covering the 1.5-bit stop interval. Falling edges inside a frame do not move the phase. The stored period is never measured again until the next reset.

The input first passes through a two-flop synchroniser. The rate limits, the rounding variant and the recommended-rate threshold are parameters.

Top module: `autobaud_gen`

## Requirements
- R1: After reset `locked`, `cal_error`, `fast_rate` and `bit_period` are 0, and no tick of any kind is issued while the block is unlocked, including during the calibration character.
- R2: If the synchronised input stays low for N consecutive clocks with 32 <= N <= 4096 and then returns high, the block locks with `bit_period` = (N + 4) >> 3 and `cal_error` = 0 (e.g. N=60 gives 8, N=59 gives 7, N=36 gives 5, N=35 gives 4).
- R3: A low stretch longer than 4096 clocks sets `cal_error` and leaves `locked` 0 and `bit_period` 0. N=4096 still locks with period 512. `locked` and `cal_error` are never 1 together.
- R4: A low stretch shorter than 32 clocks sets `cal_error` and does not lock. N=32 locks with period 4.
- R5: `fast_rate` is 1 exactly when the block is locked and `bit_period` is below 8.
- R6: Once locked, later characters of any length leave `locked` and `bit_period` unchanged until reset.
- R7: While locked and idle, a falling edge starts a frame. A one-cycle `half_tick` begins (P >> 1) + 2 clock edges after the first rising clock edge that samples the input low, where P is `bit_period`. At most one of the three tick outputs is high in any cycle.
- R8: After `half_tick`, exactly eight one-cycle `bit_tick` pulses follow, spaced P clocks apart, the first P clocks after `half_tick`.
- R9: One one-cycle `stop_tick` follows P + (P >> 1) clocks after the eighth `bit_tick`, and the frame ends there. Falling edges on the input during a frame do not shift any tick.
- R10: `cal_error` is sticky. After an error, a later valid calibration character does not lock the block before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| locked | output | 1 | Bit period measured and held |
| cal_error | output | 1 | Calibration low stretch out of range (sticky) |
| bit_period | output | 10 | Measured bit period in system clocks, 0 until locked |
| fast_rate | output | 1 | Locked period is below the recommended minimum |
| half_tick | output | 1 | Start-bit validation tick, half a period into the frame |
| bit_tick | output | 1 | Mid-bit sampling tick for each data bit |
| stop_tick | output | 1 | End of the 1.5-period stop interval |

## Verification
The hardest situation to reach is the pair of edges at the top of the measurement range. There, one extra clock of low level decides between a 512-clock lock and a sticky error, and the error has to be declared while the line is still low. The bench holds the line low for exactly 4096 and for exactly 4097 clocks, each after its own reset. It also probes the rounding boundaries and the minimum-span edge from a table of span lengths. Frames whose data bits add falling edges are sent in the middle of a frame, so tick timing is checked against absolute clock counts and shows that those edges do not move the phase.

// File: rtl/autobaud_pkg.sv
package autobaud_pkg;
   typedef enum logic [1:0] {
      MTR_IDLE  = 2'd0,
      MTR_MEAS  = 2'd1,
      MTR_LOCK  = 2'd2,
      MTR_FAULT = 2'd3
   } meter_state_t;

   typedef enum logic [1:0] {
      SEG_HALF = 2'd0,
      SEG_DATA = 2'd1,
      SEG_STOP = 2'd2
   } tick_seg_t;
endpackage

// File: rtl/autobaud_sync.sv
module autobaud_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic level,
   output logic fall,
   output logic rise
);
   logic [STAGES-1:0] pipe_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("autobaud_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         pipe_q <= '1;
         last_q <= 1'b1;
      end else begin
         pipe_q <= {pipe_q[STAGES-2:0], din};
         last_q <= pipe_q[STAGES-1];
      end
   end

   assign level = pipe_q[STAGES-1];
   assign fall  = last_q & ~level;
   assign rise  = ~last_q & level;
endmodule

// File: rtl/autobaud_meter.sv
module autobaud_meter
   import autobaud_pkg::*;
#(
   parameter int MIN_SPAN = 32,
   parameter int MAX_SPAN = 4096,
   parameter int SPAN_W   = 13,
   parameter int PER_W    = 10,
   parameter int SHIFT    = 3,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fall,
   input  logic             rise,
   output logic             locked,
   output logic             fault,
   output logic [PER_W-1:0] period
);
   localparam logic [SPAN_W:0] BIAS = ROUND_EN ? (SPAN_W+1)'(1 << (SHIFT-1)) : '0;

   meter_state_t      state_q;
   logic [SPAN_W-1:0] span_q;
   logic [SPAN_W:0]   biased;
   logic [PER_W-1:0]  per_calc;
   logic [PER_W-1:0]  period_q;

   generate
      if (SHIFT + PER_W > SPAN_W + 1) begin : g_bad_width
         $error("autobaud_meter period field exceeds span width");
      end
      if (ROUND_EN) begin : g_round
         assign biased = {1'b0, span_q} + BIAS;
      end else begin : g_trunc
         assign biased = {1'b0, span_q};
      end
   endgenerate

   assign per_calc = biased[SHIFT +: PER_W];

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= MTR_IDLE;
         span_q   <= '0;
         period_q <= '0;
      end else begin
         case (state_q)
            MTR_IDLE: begin
               if (fall) begin
                  state_q <= MTR_MEAS;
                  span_q  <= SPAN_W'(1);
               end
            end
            MTR_MEAS: begin
               if (rise) begin
                  if (span_q < SPAN_W'(MIN_SPAN)) begin
                     state_q <= MTR_FAULT;
                  end else begin
                     state_q  <= MTR_LOCK;
                     period_q <= per_calc;
                  end
               end else if (span_q == SPAN_W'(MAX_SPAN)) begin
                  state_q <= MTR_FAULT;
               end else begin
                  span_q <= span_q + SPAN_W'(1);
               end
            end
            default: state_q <= state_q;
         endcase
      end
   end

   assign locked = (state_q == MTR_LOCK);
   assign fault  = (state_q == MTR_FAULT);
   assign period = period_q;
endmodule

// File: rtl/autobaud_ticker.sv
module autobaud_ticker
   import autobaud_pkg::*;
#(
   parameter int PER_W     = 10,
   parameter int DATA_BITS = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             enable,
   input  logic             fall,
   input  logic [PER_W-1:0] period,
   output logic             half_tick,
   output logic             bit_tick,
   output logic             stop_tick
);
   localparam int TICK_W = PER_W + 1;
   localparam int NBIT_W = $clog2(DATA_BITS + 1);

   tick_seg_t         seg_q;
   logic              active_q;
   logic [TICK_W-1:0] phase_q;
   logic [TICK_W-1:0] target;
   logic [TICK_W-1:0] per_ext;
   logic [NBIT_W-1:0] nbit_q;
   logic              half_q, bit_q, stop_q;

   assign per_ext = {1'b0, period};

   always_comb begin
      case (seg_q)
         SEG_HALF: target = per_ext >> 1;
         SEG_DATA: target = per_ext;
         default:  target = per_ext + (per_ext >> 1);
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         seg_q    <= SEG_HALF;
         active_q <= 1'b0;
         phase_q  <= '0;
         nbit_q   <= '0;
         half_q   <= 1'b0;
         bit_q    <= 1'b0;
         stop_q   <= 1'b0;
      end else begin
         half_q <= 1'b0;
         bit_q  <= 1'b0;
         stop_q <= 1'b0;
         if (!active_q) begin
            if (enable && fall) begin
               active_q <= 1'b1;
               seg_q    <= SEG_HALF;
               phase_q  <= TICK_W'(1);
               nbit_q   <= '0;
            end
         end else if (phase_q == target) begin
            phase_q <= TICK_W'(1);
            case (seg_q)
               SEG_HALF: begin
                  half_q <= 1'b1;
                  seg_q  <= SEG_DATA;
               end
               SEG_DATA: begin
                  bit_q  <= 1'b1;
                  nbit_q <= nbit_q + NBIT_W'(1);
                  if (nbit_q == NBIT_W'(DATA_BITS - 1)) seg_q <= SEG_STOP;
               end
               default: begin
                  stop_q   <= 1'b1;
                  active_q <= 1'b0;
               end
            endcase
         end else begin
            phase_q <= phase_q + TICK_W'(1);
         end
      end
   end

   assign half_tick = half_q;
   assign bit_tick  = bit_q;
   assign stop_tick = stop_q;
endmodule

// File: rtl/autobaud_gen.sv
module autobaud_gen #(
   parameter int MIN_RATE_DIV = 4,
   parameter int MAX_RATE_DIV = 512,
   parameter int CAL_BITS     = 8,
   parameter int REC_DIV      = 8,
   parameter int DATA_BITS    = 8,
   parameter int SYNC_STAGES  = 2,
   parameter bit ROUND_EN     = 1'b1,
   localparam int PER_W       = $clog2(MAX_RATE_DIV + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rx_in,
   output logic             locked,
   output logic             cal_error,
   output logic [PER_W-1:0] bit_period,
   output logic             fast_rate,
   output logic             half_tick,
   output logic             bit_tick,
   output logic             stop_tick
);
   localparam int MIN_SPAN = CAL_BITS * MIN_RATE_DIV;
   localparam int MAX_SPAN = CAL_BITS * MAX_RATE_DIV;
   localparam int SPAN_W   = $clog2(MAX_SPAN + 1);
   localparam int SHIFT    = $clog2(CAL_BITS);

   generate
      if ((1 << SHIFT) != CAL_BITS) begin : g_bad_cal
         $error("CAL_BITS must be a power of two");
      end
      if (MIN_RATE_DIV < 2 || MIN_RATE_DIV > MAX_RATE_DIV) begin : g_bad_range
         $error("rate divider range is invalid");
      end
   endgenerate

   logic rx_level, rx_fall, rx_rise;

   autobaud_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst   (rst),
      .din   (rx_in),
      .level (rx_level),
      .fall  (rx_fall),
      .rise  (rx_rise)
   );

   autobaud_meter #(
      .MIN_SPAN (MIN_SPAN),
      .MAX_SPAN (MAX_SPAN),
      .SPAN_W   (SPAN_W),
      .PER_W    (PER_W),
      .SHIFT    (SHIFT),
      .ROUND_EN (ROUND_EN)
   ) u_meter (
      .clk    (clk),
      .rst    (rst),
      .fall   (rx_fall),
      .rise   (rx_rise),
      .locked (locked),
      .fault  (cal_error),
      .period (bit_period)
   );

   autobaud_ticker #(.PER_W(PER_W), .DATA_BITS(DATA_BITS)) u_ticker (
      .clk       (clk),
      .rst       (rst),
      .enable    (locked),
      .fall      (rx_fall),
      .period    (bit_period),
      .half_tick (half_tick),
      .bit_tick  (bit_tick),
      .stop_tick (stop_tick)
   );

   assign fast_rate = locked && (bit_period < PER_W'(REC_DIV));

   logic unused_level;
   assign unused_level = rx_level;
endmodule

// File: rtl/autobaud_gen_chk.sv
module autobaud_gen_chk #(
   parameter int PER_W   = 10,
   parameter int MIN_PER = 4,
   parameter int MAX_PER = 512
) (
   input logic             clk,
   input logic             rst,
   input logic             locked,
   input logic             cal_error,
   input logic [PER_W-1:0] bit_period,
   input logic             fast_rate,
   input logic             half_tick,
   input logic             bit_tick,
   input logic             stop_tick
);
   AST_TICKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      $onehot0({half_tick, bit_tick, stop_tick})); // R7
   AST_NO_TICK_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
      !locked |-> !(half_tick || bit_tick || stop_tick)); // R1
   AST_LOCK_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(locked && cal_error)); // R3
   AST_PERIOD_RANGE: assert property (@(posedge clk) disable iff (rst)
      locked |-> (bit_period >= PER_W'(MIN_PER) && bit_period <= PER_W'(MAX_PER))); // R2
   AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (rst)
      locked |=> (locked && $stable(bit_period))); // R6
   AST_FAST_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
      fast_rate |-> locked); // R5
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
      cal_error |=> cal_error); // R10
endmodule

bind autobaud_gen autobaud_gen_chk #(
   .PER_W   (PER_W),
   .MIN_PER (MIN_RATE_DIV),
   .MAX_PER (MAX_RATE_DIV)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .locked     (locked),
   .cal_error  (cal_error),
   .bit_period (bit_period),
   .fast_rate  (fast_rate),
   .half_tick  (half_tick),
   .bit_tick   (bit_tick),
   .stop_tick  (stop_tick)
);

// File: tb/autobaud_gen_bench.sv
module autobaud_gen_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 11;
   // span, lock, err, period, fast
   localparam int VEC [NVEC][5] = '{
      '{32,   1, 0, 4,   1},
      '{31,   0, 1, 0,   0},
      '{20,   0, 1, 0,   0},
      '{64,   1, 0, 8,   0},
      '{60,   1, 0, 8,   0},
      '{59,   1, 0, 7,   1},
      '{35,   1, 0, 4,   1},
      '{36,   1, 0, 5,   1},
      '{100,  1, 0, 13,  0},
      '{4096, 1, 0, 512, 0},
      '{4097, 0, 1, 0,   0}
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       rx_in = 1'b1;
   logic       locked, cal_error, fast_rate, half_tick, bit_tick, stop_tick;
   logic [9:0] bit_period;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int n_half, n_bit, n_stop, t_half, t_bit1, t_bit8, t_stop, t_prev, sp_bad, exp_p;

   autobaud_gen u_autobaud_gen (
      .clk(clk), .rst(rst), .rx_in(rx_in), .locked(locked), .cal_error(cal_error),
      .bit_period(bit_period), .fast_rate(fast_rate), .half_tick(half_tick),
      .bit_tick(bit_tick), .stop_tick(stop_tick)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (half_tick) begin n_half++; t_half = cyc; end
      if (bit_tick) begin
         n_bit++;
         if (n_bit == 1) t_bit1 = cyc;
         else if (cyc - t_prev != exp_p) sp_bad++;
         t_prev = cyc;
         t_bit8 = cyc;
      end
      if (stop_tick) begin n_stop++; t_stop = cyc; end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic clear_mon();
      n_half = 0; n_bit = 0; n_stop = 0; sp_bad = 0;
      t_half = 0; t_bit1 = 0; t_bit8 = 0; t_stop = 0; t_prev = 0;
   endtask

   task automatic do_reset();
      @(posedge clk); #1 rst = 1'b1; rx_in = 1'b1;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      repeat (3) @(posedge clk);
   endtask

   task automatic cal(input int n);
      @(posedge clk); #1 rx_in = 1'b0;
      repeat (n) @(posedge clk);
      #1 rx_in = 1'b1;
      repeat (20) @(posedge clk);
   endtask

   // sends one frame of byte b at period p, returns the start reference edge
   task automatic frame(input int p, input logic [7:0] b, output int kc);
      @(posedge clk); #1 rx_in = 1'b0; kc = cyc;
      repeat (p) @(posedge clk);
      for (int i = 0; i < 8; i++) begin
         #1 rx_in = b[i];
         repeat (p) @(posedge clk);
      end
      #1 rx_in = 1'b1;
      repeat (3 * p + 10) @(posedge clk);
   endtask

   task automatic frame_test(input int span, input int p, input logic [7:0] b);
      int kc;
      int h;
      h = p / 2;
      do_reset();
      cal(span);
      chk("R2 frame lock", int'(locked), 1);
      chk("R2 frame period", int'(bit_period), p);
      clear_mon();
      exp_p = p;
      frame(p, b, kc);
      chk("R7 half count", n_half, 1);
      chk("R7 half time", t_half, kc + 3 + h);
      chk("R8 bit count", n_bit, 8);
      chk("R8 first bit time", t_bit1, kc + 3 + h + p);
      chk("R8 bit spacing errors", sp_bad, 0);
      chk("R9 stop count", n_stop, 1);
      chk("R9 stop time", t_stop, t_bit8 + p + h);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int kc;
      clear_mon();
      exp_p = 0;
      do_reset();
      repeat (50) @(posedge clk);
      @(negedge clk);
      chk("R1 reset locked", int'(locked), 0);
      chk("R1 reset error", int'(cal_error), 0);
      chk("R1 reset period", int'(bit_period), 0);
      chk("R1 reset fast", int'(fast_rate), 0);
      chk("R1 idle ticks", n_half + n_bit + n_stop, 0);

      for (int v = 0; v < NVEC; v++) begin
         string tag;
         do_reset();
         clear_mon();
         cal(VEC[v][0]);
         @(negedge clk);
         if (VEC[v][0] < 32) tag = "R4";
         else if (VEC[v][0] > 4096) tag = "R3";
         else tag = "R2";
         chk({tag, " locked"}, int'(locked), VEC[v][1]);
         chk({tag, " error"}, int'(cal_error), VEC[v][2]);
         chk({tag, " period"}, int'(bit_period), VEC[v][3]);
         chk("R5 fast flag", int'(fast_rate), VEC[v][4]);
         chk("R1 no ticks while calibrating", n_half + n_bit + n_stop, 0);
      end

      // R6: recalibration attempt after lock
      do_reset();
      cal(64);
      clear_mon();
      cal(100);
      repeat (150) @(posedge clk);
      @(negedge clk);
      chk("R6 still locked", int'(locked), 1);
      chk("R6 period held", int'(bit_period), 8);

      // R10: error is sticky
      do_reset();
      cal(20);
      cal(64);
      @(negedge clk);
      chk("R10 error held", int'(cal_error), 1);
      chk("R10 no lock after error", int'(locked), 0);

      // R7 R8 R9 framing with mid-frame falling edges
      frame_test(64, 8, 8'h55);
      frame_test(100, 13, 8'hA5);
      frame_test(32, 4, 8'h33);

      // R9: back-to-back frames, second one restarts phase
      do_reset();
      cal(64);
      clear_mon();
      exp_p = 8;
      frame(8, 8'h00, kc);
      clear_mon();
      frame(8, 8'hF0, kc);
      chk("R9 second frame half time", t_half, kc + 3 + 4);
      chk("R9 second frame stop count", n_stop, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule